// File: doc/BRIEF.md
# CCD Line Statistics Unit

This block sits behind the digitizer of a two-channel linear image sensor and reduces each scanned line to a small set of quality figures. Samples arrive one per handshake on a valid/ready stream. Each sample is tagged as belonging to an active photocell or not (dummy, shielded and invalid cells are marked inactive) and, for active cells, as an odd or even pixel. The last sample of a line carries an end-of-line marker and a flag saying whether the lamp was on for that line.

From the active pixels of one line the block forms the integer line mean, the largest excursion of any pixel from that mean (found from the running minimum and maximum, so the line is never stored), and the odd/even register imbalance as a signed fixed-point fraction. Across lines it follows one chosen pixel position and, after a fixed run of good lines, reports that pixel's mean and variance. When a dark line directly follows a lit line it also reports the dark-to-lit mean ratio, which measures image lag. Both fractions come from one shared sequential divider. All figures are published together with a one-cycle done strobe; a line with the wrong number of active pixels is rejected with an error flag.

Top module: `ccd_line_stats`

## Requirements
- R1: `in_ready` is 1 while the block collects a line; a sample is taken on a clock edge where `in_valid` and `in_ready` are both 1; after the sample with `in_last`=1 is taken, `in_ready` is 0 until the line has been judged, and samples with `in_pix_ok`=0 have no effect on any result.
- R2: For a good line (exactly LINE_PIX samples with `in_pix_ok`=1), `res_avg` is the sum of the active pixel values divided by LINE_PIX, rounded down.
- R3: `res_peak` is the larger of (line maximum minus `res_avg`) and (`res_avg` minus line minimum), over the active pixels of the line.
- R4: `res_imbal` is a two's complement value with FRAC_W fractional bits equal to 2·|Sodd − Seven|·2^FRAC_W / Sall rounded down in magnitude, negative when Seven > Sodd, where Sodd and Seven are the sums of active pixels with `in_odd`=1 and `in_odd`=0; it is 0 when Sall is 0.
- R5: When a good line whose last sample had `in_lit`=0 follows a good line whose last sample had `in_lit`=1, `res_lag` becomes ⌊avg_now·2^FRAC_W / avg_before⌋ (0 if avg_before is 0) and `res_lag_new` is 1 in that done cycle; otherwise `res_lag` keeps its value and `res_lag_new` is 0.
- R6: In each good line the active pixel with zero-based active index `cfg_sel_idx` is recorded; after NOISE_LINES good lines `res_noise_mean` = ⌊Σx/N⌋ and `res_noise_var` = ⌊Σx²/N⌋ − mean², `res_noise_new` is 1 in that done cycle, and a new run starts.
- R7: A line ending with fewer or more than LINE_PIX active samples sets `res_err` to 1, raises no done strobe, leaves every result unchanged and is not counted for R5 or R6; `res_err` returns to 0 with the next done strobe.
- R8: `res_done` is high for exactly one cycle per good line, all results change only in that cycle and hold their values otherwise.
- R9: After reset all results, `res_done` and `res_err` are 0 and `in_ready` is 1.
- R10: A line with every active pixel at full scale produces exact results with no accumulator wrap (mean full scale, peak 0, imbalance 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Sample present |
| in_ready | output | 1 | Block accepts a sample |
| in_data | input | DATA_W | Digitized pixel value |
| in_pix_ok | input | 1 | Sample belongs to an active photocell |
| in_odd | input | 1 | Active pixel is an odd pixel |
| in_last | input | 1 | Last sample of the line |
| in_lit | input | 1 | Lamp on for this line (read with the last sample) |
| cfg_sel_idx | input | clog2(LINE_PIX) | Active pixel index followed for noise |
| res_avg | output | DATA_W | Line mean |
| res_peak | output | DATA_W | Largest deviation from the mean |
| res_imbal | output | FRAC_W+3 | Signed odd/even imbalance fraction |
| res_lag | output | DATA_W+FRAC_W | Dark-to-lit mean ratio |
| res_lag_new | output | 1 | Lag ratio updated with this done |
| res_noise_mean | output | DATA_W | Mean of the followed pixel |
| res_noise_var | output | 2*DATA_W | Variance of the followed pixel |
| res_noise_new | output | 1 | Noise figures updated with this done |
| res_done | output | 1 | One-cycle strobe, results updated |
| res_err | output | 1 | Last judged line had a wrong pixel count |

## Verification
The bench builds the block with LINE_PIX=8 and NOISE_LINES=4 while keeping DATA_W=16 and FRAC_W=16. Short lines put both count errors (seven and nine active pixels), the odd/even pairing and the chosen-pixel capture within a few samples, and a four-line run lets several noise windows close, including one with a constant pixel and zero variance. Keeping the full 16-bit data path means full-scale lines still reach the top of every accumulator and of the divider operands.

// File: rtl/ccd_stat_pkg.sv
// Shared types of the line statistics unit.
// Assumes: nothing beyond IEEE 1800-2017.
package ccd_stat_pkg;

    // Sequencer states: collect, judge, two divisions, publish.
    typedef enum logic [2:0] {
        ST_RUN      = 3'd0,
        ST_CLOSE    = 3'd1,
        ST_IMB_GO   = 3'd2,
        ST_IMB_WAIT = 3'd3,
        ST_LAG_GO   = 3'd4,
        ST_LAG_WAIT = 3'd5,
        ST_PUB      = 3'd6
    } stat_state_t;

endpackage

// File: rtl/ccd_line_accum.sv
// Per-line accumulator: odd and even sums, minimum, maximum, active count
// and the value of one chosen active pixel.
// Assumes: clear is held for one cycle between lines; the count saturates
// one above LINE_PIX so over-long lines remain detectable.
module ccd_line_accum #(
    parameter int DATA_W   = 16,
    parameter int LINE_PIX = 7400,
    parameter int SUM_W    = 29,
    parameter int CNT_W    = 13,
    parameter int IDX_W    = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              clear,
    input  logic [DATA_W-1:0] data,
    input  logic              pix_ok,
    input  logic              odd,
    input  logic [IDX_W-1:0]  sel_idx,
    output logic [SUM_W-1:0]  sum_odd,
    output logic [SUM_W-1:0]  sum_even,
    output logic [SUM_W-1:0]  sum_all,
    output logic [DATA_W-1:0] pmin,
    output logic [DATA_W-1:0] pmax,
    output logic [CNT_W-1:0]  count,
    output logic [DATA_W-1:0] sel_val
);
    localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(LINE_PIX + 1);

    logic hit;
    assign hit     = take && pix_ok;
    assign sum_all = sum_odd + sum_even;

    // Fold each active pixel into the running line figures.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sum_odd  <= '0;
            sum_even <= '0;
            pmin     <= '1;
            pmax     <= '0;
            count    <= '0;
            sel_val  <= '0;
        end else if (hit) begin
            if (odd) sum_odd  <= sum_odd  + SUM_W'(data);
            else     sum_even <= sum_even + SUM_W'(data);
            if (data < pmin) pmin <= data;
            if (data > pmax) pmax <= data;
            if (count != CNT_SAT) count <= count + 1'b1;
            if (count == CNT_W'(sel_idx)) sel_val <= data;
        end
    end
endmodule

// File: rtl/ccd_noise_accum.sv
// Follows one pixel over a run of NLINES good lines and produces its mean
// and variance (mean of squares minus square of mean, both floored).
// Assumes: add pulses once per good line; full_o stays set until the next add.
module ccd_noise_accum #(
    parameter int DATA_W = 16,
    parameter int NLINES = 100
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                add,
    input  logic [DATA_W-1:0]   sample,
    output logic [DATA_W-1:0]   mean_o,
    output logic [2*DATA_W-1:0] var_o,
    output logic                full_o
);
    localparam int LC_W   = $clog2(NLINES + 1);
    localparam int NSUM_W = DATA_W + LC_W;
    localparam int SQ_W   = 2 * DATA_W + LC_W;
    localparam logic [NSUM_W-1:0] NL_S    = NSUM_W'(NLINES);
    localparam logic [SQ_W-1:0]   NL_Q    = SQ_W'(NLINES);
    localparam logic [LC_W-1:0]   LC_LAST = LC_W'(NLINES - 1);

    logic [NSUM_W-1:0]   acc_sum, sum_n;
    logic [SQ_W-1:0]     acc_sq, sq_n;
    logic [LC_W-1:0]     lines;
    logic [2*DATA_W-1:0] sq_s, msq, qsq;
    logic [DATA_W-1:0]   mean_n;

    // Next sums and the statistics they would give if the run closed now.
    always_comb begin
        sq_s   = sample * sample;
        sum_n  = acc_sum + NSUM_W'(sample);
        sq_n   = acc_sq + SQ_W'(sq_s);
        mean_n = DATA_W'(sum_n / NL_S);
        msq    = mean_n * mean_n;
        qsq    = (2*DATA_W)'(sq_n / NL_Q);
    end

    // Accumulate one sample per good line; close the run after NLINES.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_sum <= '0;
            acc_sq  <= '0;
            lines   <= '0;
            mean_o  <= '0;
            var_o   <= '0;
            full_o  <= 1'b0;
        end else if (add) begin
            if (lines == LC_LAST) begin
                acc_sum <= '0;
                acc_sq  <= '0;
                lines   <= '0;
                mean_o  <= mean_n;
                var_o   <= qsq - msq;
                full_o  <= 1'b1;
            end else begin
                acc_sum <= sum_n;
                acc_sq  <= sq_n;
                lines   <= lines + 1'b1;
                full_o  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ccd_seq_div.sv
// Restoring unsigned divider, one quotient bit per cycle.
// Assumes: start only while idle; a zero divisor yields a zero quotient.
module ccd_seq_div #(
    parameter int NUM_W = 46,
    parameter int DEN_W = 29,
    parameter int Q_W   = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [Q_W-1:0]   quot
);
    localparam int IT_W = $clog2(NUM_W + 1);

    logic [DEN_W-1:0] rem, den_r;
    logic [NUM_W-1:0] qn;
    logic [IT_W-1:0]  iter;
    logic             den_zero;
    logic [DEN_W:0]   shifted;
    logic             fits;

    assign shifted = {rem, qn[NUM_W-1]};
    assign fits    = shifted >= {1'b0, den_r};
    assign quot    = den_zero ? '0 : qn[Q_W-1:0];

    // Shift one numerator bit into the remainder per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem      <= '0;
            den_r    <= '0;
            qn       <= '0;
            iter     <= '0;
            den_zero <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                rem      <= '0;
                den_r    <= den;
                qn       <= num;
                iter     <= IT_W'(NUM_W);
                den_zero <= (den == '0);
            end else if (iter != '0) begin
                rem  <= fits ? DEN_W'(shifted - {1'b0, den_r}) : shifted[DEN_W-1:0];
                qn   <= {qn[NUM_W-2:0], fits};
                iter <= iter - 1'b1;
                if (iter == IT_W'(1)) done <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/ccd_line_stats.sv
// Line statistics unit: collects one line of tagged samples, judges its
// active pixel count, then derives mean, peak deviation, odd/even imbalance,
// lag ratio and per-pixel noise, publishing all with a one-cycle done.
// Assumes: cfg_sel_idx is static during a line; in_lit is read with the
// last sample; in_ready is low while a line is being evaluated.
module ccd_line_stats
    import ccd_stat_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int LINE_PIX    = 7400,
    parameter int NOISE_LINES = 100,
    parameter int FRAC_W      = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    output logic                          in_ready,
    input  logic [DATA_W-1:0]             in_data,
    input  logic                          in_pix_ok,
    input  logic                          in_odd,
    input  logic                          in_last,
    input  logic                          in_lit,
    input  logic [$clog2(LINE_PIX)-1:0]   cfg_sel_idx,
    output logic [DATA_W-1:0]             res_avg,
    output logic [DATA_W-1:0]             res_peak,
    output logic [FRAC_W+2:0]             res_imbal,
    output logic [DATA_W+FRAC_W-1:0]      res_lag,
    output logic                          res_lag_new,
    output logic [DATA_W-1:0]             res_noise_mean,
    output logic [2*DATA_W-1:0]           res_noise_var,
    output logic                          res_noise_new,
    output logic                          res_done,
    output logic                          res_err
);
    localparam int IDX_W = $clog2(LINE_PIX);
    localparam int CNT_W = $clog2(LINE_PIX + 2);
    localparam int SUM_W = DATA_W + $clog2(LINE_PIX + 1);
    localparam int NUM_W = SUM_W + 1 + FRAC_W;
    localparam int QW    = DATA_W + FRAC_W;
    localparam int IMB_W = FRAC_W + 3;
    localparam logic [SUM_W-1:0] LP_S   = SUM_W'(LINE_PIX);
    localparam logic [CNT_W-1:0] LP_CNT = CNT_W'(LINE_PIX);

    stat_state_t state;

    logic               take, line_clear, good, noise_add;
    logic [SUM_W-1:0]   sum_odd, sum_even, sum_all;
    logic [DATA_W-1:0]  pmin, pmax, sel_val;
    logic [CNT_W-1:0]   count;
    logic [DATA_W-1:0]  avg_c, up_c, dn_c, peak_c;
    logic [SUM_W-1:0]   mag_c;

    logic               lit_cur, prev_lit, lag_hit, p_neg;
    logic [DATA_W-1:0]  prev_avg, p_avg, p_peak;
    logic [SUM_W-1:0]   p_mag, p_sum;
    logic [IMB_W-1:0]   p_imbal, imb_q;
    logic [QW-1:0]      p_lag;

    logic               div_start, div_done;
    logic [NUM_W-1:0]   div_num;
    logic [SUM_W-1:0]   div_den;
    logic [QW-1:0]      div_quot;

    logic [DATA_W-1:0]   noise_mean;
    logic [2*DATA_W-1:0] noise_var;
    logic                noise_full;

    assign in_ready   = (state == ST_RUN);
    assign take       = in_valid && in_ready;
    assign line_clear = (state == ST_CLOSE);
    assign good       = (count == LP_CNT);
    assign noise_add  = line_clear && good;

    ccd_line_accum #(
        .DATA_W(DATA_W), .LINE_PIX(LINE_PIX), .SUM_W(SUM_W),
        .CNT_W(CNT_W), .IDX_W(IDX_W)
    ) u_acc (
        .clk(clk), .rst_n(rst_n), .take(take), .clear(line_clear),
        .data(in_data), .pix_ok(in_pix_ok), .odd(in_odd), .sel_idx(cfg_sel_idx),
        .sum_odd(sum_odd), .sum_even(sum_even), .sum_all(sum_all),
        .pmin(pmin), .pmax(pmax), .count(count), .sel_val(sel_val)
    );

    ccd_noise_accum #(.DATA_W(DATA_W), .NLINES(NOISE_LINES)) u_noise (
        .clk(clk), .rst_n(rst_n), .add(noise_add), .sample(sel_val),
        .mean_o(noise_mean), .var_o(noise_var), .full_o(noise_full)
    );

    ccd_seq_div #(.NUM_W(NUM_W), .DEN_W(SUM_W), .Q_W(QW)) u_div (
        .clk(clk), .rst_n(rst_n), .start(div_start), .num(div_num),
        .den(div_den), .done(div_done), .quot(div_quot)
    );

    // Line figures derived from the closed accumulators.
    always_comb begin
        avg_c  = DATA_W'(sum_all / LP_S);
        up_c   = pmax - avg_c;
        dn_c   = avg_c - pmin;
        peak_c = (up_c > dn_c) ? up_c : dn_c;
        mag_c  = (sum_odd >= sum_even) ? (sum_odd - sum_even) : (sum_even - sum_odd);
    end

    // Divider operands: imbalance first, then the optional lag ratio.
    always_comb begin
        div_start = (state == ST_IMB_GO) || (state == ST_LAG_GO);
        if (state == ST_IMB_GO) begin
            div_num = {p_mag, 1'b0, {FRAC_W{1'b0}}};
            div_den = p_sum;
        end else begin
            div_num = {{(SUM_W + 1 - DATA_W){1'b0}}, p_avg, {FRAC_W{1'b0}}};
            div_den = {{(SUM_W - DATA_W){1'b0}}, prev_avg};
        end
        imb_q = div_quot[IMB_W-1:0];
    end

    // Sequencer: judge the line, run the divisions, publish together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state          <= ST_RUN;
            lit_cur        <= 1'b0;
            prev_lit       <= 1'b0;
            prev_avg       <= '0;
            lag_hit        <= 1'b0;
            p_neg          <= 1'b0;
            p_avg          <= '0;
            p_peak         <= '0;
            p_mag          <= '0;
            p_sum          <= '0;
            p_imbal        <= '0;
            p_lag          <= '0;
            res_avg        <= '0;
            res_peak       <= '0;
            res_imbal      <= '0;
            res_lag        <= '0;
            res_lag_new    <= 1'b0;
            res_noise_mean <= '0;
            res_noise_var  <= '0;
            res_noise_new  <= 1'b0;
            res_done       <= 1'b0;
            res_err        <= 1'b0;
        end else begin
            res_done      <= 1'b0;
            res_lag_new   <= 1'b0;
            res_noise_new <= 1'b0;
            case (state)
                ST_RUN: begin
                    if (take && in_last) begin
                        lit_cur <= in_lit;
                        state   <= ST_CLOSE;
                    end
                end
                ST_CLOSE: begin
                    if (good) begin
                        p_avg   <= avg_c;
                        p_peak  <= peak_c;
                        p_mag   <= mag_c;
                        p_sum   <= sum_all;
                        p_neg   <= sum_even > sum_odd;
                        lag_hit <= prev_lit && !lit_cur;
                        state   <= ST_IMB_GO;
                    end else begin
                        res_err <= 1'b1;
                        state   <= ST_RUN;
                    end
                end
                ST_IMB_GO:  state <= ST_IMB_WAIT;
                ST_IMB_WAIT: begin
                    if (div_done) begin
                        p_imbal <= p_neg ? (~imb_q + 1'b1) : imb_q;
                        state   <= lag_hit ? ST_LAG_GO : ST_PUB;
                    end
                end
                ST_LAG_GO:  state <= ST_LAG_WAIT;
                ST_LAG_WAIT: begin
                    if (div_done) begin
                        p_lag <= div_quot;
                        state <= ST_PUB;
                    end
                end
                ST_PUB: begin
                    res_avg     <= p_avg;
                    res_peak    <= p_peak;
                    res_imbal   <= p_imbal;
                    res_lag_new <= lag_hit;
                    if (lag_hit) res_lag <= p_lag;
                    res_noise_new <= noise_full;
                    if (noise_full) begin
                        res_noise_mean <= noise_mean;
                        res_noise_var  <= noise_var;
                    end
                    res_done <= 1'b1;
                    res_err  <= 1'b0;
                    prev_avg <= p_avg;
                    prev_lit <= lit_cur;
                    state    <= ST_RUN;
                end
                default: state <= ST_RUN;
            endcase
        end
    end
endmodule

// File: rtl/ccd_line_stats_chk.sv
// Checker for the line statistics unit, bound to every instance.
// Assumes: synchronous active-low reset; all checks are off during reset.
module ccd_line_stats_chk #(
    parameter int DATA_W = 16,
    parameter int IMB_W  = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              in_last,
    input logic              res_done,
    input logic              res_err,
    input logic              res_lag_new,
    input logic              res_noise_new,
    input logic [DATA_W-1:0] res_avg,
    input logic [DATA_W-1:0] res_peak,
    input logic [IMB_W-1:0]  res_imbal
);
    AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_last) |=> !in_ready); // R1
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        res_done |=> !res_done); // R8
    AST_RESULTS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !res_done |-> ($stable(res_avg) && $stable(res_peak) && $stable(res_imbal))); // R8
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        res_err |-> !res_done); // R7
    AST_LAG_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        res_lag_new |-> res_done); // R5
    AST_NOISE_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        res_noise_new |-> res_done); // R6
endmodule

bind ccd_line_stats ccd_line_stats_chk #(.DATA_W(DATA_W), .IMB_W(FRAC_W + 3)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_last(in_last), .res_done(res_done), .res_err(res_err),
    .res_lag_new(res_lag_new), .res_noise_new(res_noise_new),
    .res_avg(res_avg), .res_peak(res_peak), .res_imbal(res_imbal)
);

// File: tb/ccd_line_stats_test.sv
// Bench: random and directed lines, expected figures from reference functions.
module ccd_line_stats_test;
    localparam int DW  = 16;
    localparam int LP  = 8;
    localparam int NL  = 4;
    localparam int FW  = 16;
    localparam int SEL = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_pix_ok = 1'b0, in_odd = 1'b0, in_last = 1'b0, in_lit = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic [$clog2(LP)-1:0] cfg_sel_idx = SEL;
    logic in_ready, res_lag_new, res_noise_new, res_done, res_err;
    logic [DW-1:0] res_avg, res_peak, res_noise_mean;
    logic [FW+2:0] res_imbal;
    logic [DW+FW-1:0] res_lag;
    logic [2*DW-1:0] res_noise_var;

    always #10 clk = ~clk;

    ccd_line_stats #(.DATA_W(DW), .LINE_PIX(LP), .NOISE_LINES(NL), .FRAC_W(FW)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_pix_ok(in_pix_ok), .in_odd(in_odd), .in_last(in_last),
        .in_lit(in_lit), .cfg_sel_idx(cfg_sel_idx), .res_avg(res_avg), .res_peak(res_peak),
        .res_imbal(res_imbal), .res_lag(res_lag), .res_lag_new(res_lag_new),
        .res_noise_mean(res_noise_mean), .res_noise_var(res_noise_var),
        .res_noise_new(res_noise_new), .res_done(res_done), .res_err(res_err)
    );

    int checks = 0;
    int fails = 0;
    bit finished = 0;
    logic [DW-1:0] pix [0:15];

    // Reference state
    longint e_avg = 0, e_peak = 0, e_imb = 0, e_lag = 0, e_nmean = 0, e_nvar = 0;
    longint m_prev_avg = 0, n_sum = 0, n_sq = 0;
    bit m_prev_lit = 0;
    int n_cnt = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic longint ref_avg(input longint s);
        return s / LP;
    endfunction

    function automatic longint ref_imb(input longint so, input longint se);
        longint s, mag;
        s = so + se;
        if (s == 0) return 0;
        mag = ((2 * ((so >= se) ? so - se : se - so)) << FW) / s;
        return (se > so) ? -mag : mag;
    endfunction

    function automatic longint ref_lag(input longint now_a, input longint before_a);
        if (before_a == 0) return 0;
        return (now_a << FW) / before_a;
    endfunction

    task automatic put(input logic [DW-1:0] d, input bit ok, input bit odd, input bit last, input bit lit);
        in_valid = 1'b1; in_data = d; in_pix_ok = ok; in_odd = odd; in_last = last; in_lit = lit;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic send_line(input int nv, input bit lit);
        longint s = 0, so = 0, se = 0, mn = 65535, mx = 0, avg, up, dn;
        bit lag_exp, noise_exp, seen;
        int t;
        @(negedge clk);
        for (int k = 0; k < nv; k++) begin
            repeat ($urandom_range(0, 2)) put(DW'($urandom), 1'b0, $urandom_range(0, 1) == 1, 1'b0, lit);
            put(pix[k], 1'b1, (k % 2) == 0, k == nv - 1, lit);
        end
        chk(in_ready == 1'b0, "R1 ready low after last", in_ready, 0);
        if (nv == LP) begin
            for (int k = 0; k < LP; k++) begin
                s += pix[k];
                if (k % 2 == 0) so += pix[k]; else se += pix[k];
                if (pix[k] < mn) mn = pix[k];
                if (pix[k] > mx) mx = pix[k];
            end
            avg = ref_avg(s);
            up = mx - avg; dn = avg - mn;
            e_avg = avg;
            e_peak = (up > dn) ? up : dn;
            e_imb = ref_imb(so, se);
            lag_exp = m_prev_lit && !lit;
            if (lag_exp) e_lag = ref_lag(avg, m_prev_avg);
            n_sum += pix[SEL]; n_sq += longint'(pix[SEL]) * pix[SEL]; n_cnt++;
            noise_exp = (n_cnt == NL);
            if (noise_exp) begin
                e_nmean = n_sum / NL;
                e_nvar = n_sq / NL - e_nmean * e_nmean;
                n_sum = 0; n_sq = 0; n_cnt = 0;
            end
            m_prev_avg = avg; m_prev_lit = lit;
            t = 0;
            while (!res_done && t < 3000) begin @(negedge clk); t++; end
            chk(res_done == 1'b1, "R8 done strobe seen", res_done, 1);
            chk(res_avg == e_avg, "R2 line mean", res_avg, e_avg);
            chk(res_peak == e_peak, "R3 peak deviation", res_peak, e_peak);
            chk($signed(res_imbal) == e_imb, "R4 imbalance", $signed(res_imbal), e_imb);
            chk(res_lag_new == lag_exp, "R5 lag update flag", res_lag_new, lag_exp);
            chk(res_lag == e_lag, "R5 lag ratio", res_lag, e_lag);
            chk(res_noise_new == noise_exp, "R6 noise update flag", res_noise_new, noise_exp);
            chk(res_noise_mean == e_nmean, "R6 noise mean", res_noise_mean, e_nmean);
            chk(res_noise_var == e_nvar, "R6 noise variance", res_noise_var, e_nvar);
            chk(res_err == 1'b0, "R7 error cleared on done", res_err, 0);
            @(negedge clk);
            chk(res_done == 1'b0, "R8 done single cycle", res_done, 0);
        end else begin
            seen = 0;
            repeat (30) begin @(negedge clk); if (res_done) seen = 1; end
            chk(!seen, "R7 no done on bad line", seen, 0);
            chk(res_err == 1'b1, "R7 error flag", res_err, 1);
            chk(res_avg == e_avg, "R7 mean unchanged", res_avg, e_avg);
            chk(res_peak == e_peak, "R7 peak unchanged", res_peak, e_peak);
            chk($signed(res_imbal) == e_imb, "R7 imbalance unchanged", $signed(res_imbal), e_imb);
            chk(in_ready == 1'b1, "R1 ready after rejection", in_ready, 1);
        end
    endtask

    task automatic fill_rand(input int lo, input int hi);
        for (int k = 0; k < 16; k++) pix[k] = DW'($urandom_range(lo, hi));
    endtask

    task automatic fill_const(input int v);
        for (int k = 0; k < 16; k++) pix[k] = DW'(v);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin : main
        void'($urandom(32'd20240517));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk(in_ready == 1'b1, "R9 ready after reset", in_ready, 1);
        chk(res_done == 1'b0 && res_err == 1'b0, "R9 done/err after reset", {res_done, res_err}, 0);
        chk(res_avg == 0 && res_peak == 0 && res_imbal == 0, "R9 line results after reset", res_avg, 0);
        chk(res_lag == 0 && res_noise_var == 0 && res_noise_mean == 0, "R9 other results after reset", res_lag, 0);

        fill_rand(0, 65535); send_line(LP, 1);
        fill_rand(1000, 60000); send_line(LP, 1);
        fill_rand(0, 9000); send_line(LP, 0);      // R5 lag event
        fill_rand(0, 65535); send_line(LP, 0);     // no lag, R6 run closes
        fill_rand(0, 65535); send_line(LP - 1, 1); // R7 short line
        fill_rand(0, 65535); send_line(LP + 1, 1); // R7 long line
        fill_const(65535); send_line(LP, 1);       // R10 full scale
        fill_rand(100, 30000); send_line(LP, 0);   // R5 ratio below one
        fill_const(0); send_line(LP, 1);           // R4 zero sum
        fill_rand(0, 500); send_line(LP, 0);       // R5 zero lit mean
        // Odd-heavy then even-heavy lines, followed pixel held constant (R6 zero variance)
        for (int k = 0; k < 16; k++) pix[k] = (k % 2 == 0) ? 16'd60000 : 16'd100;
        pix[SEL] = 16'd1234; send_line(LP, 1);
        for (int k = 0; k < 16; k++) pix[k] = (k % 2 == 0) ? 16'd100 : 16'd60000;
        pix[SEL] = 16'd1234; send_line(LP, 0);
        fill_rand(0, 65535); pix[SEL] = 16'd1234; send_line(LP, 1);
        fill_rand(0, 65535); pix[SEL] = 16'd1234; send_line(LP, 1);
        for (int i = 0; i < 16; i++) begin
            fill_rand(0, 65535);
            send_line(($urandom_range(0, 7) == 0) ? LP - 1 : LP, $urandom_range(0, 1) == 1);
        end
        fill_rand(0, 65535); send_line(LP, 1);
        finish_run();
    end
endmodule